// File: doc/BRIEF.md
# Serial Receiver with Break Wake-Up

An 8-data-bit, no-parity, one-stop-bit asynchronous receiver that samples the line on a 16x baud tick. Each received byte lands in a data register, raises a receive interrupt and updates a framing error flag. Reading the data register clears the interrupt.

The receiver also has a wake-up mode. While software has the mode armed, the receiver stays idle and ignores all line activity. It watches only for the first falling edge on the RX line, which is the start of a break. That edge sets a capture flop directly, through the RX pin acting as its clock. The capture flop drives a wake request and raises the interrupt. The data register is loaded with a dummy zero. Once the line has returned high after the event, the mode disarms itself and normal reception resumes.

A sleep input gates the baud tick. Edge capture and the self-clear do not use the baud tick. While sleep is asserted, the interrupt output also follows the capture flop combinationally, so it rises without any clock edge.

Top module: `uart_wake_rx`

## Requirements
- R1: A frame made of a low start bit, 8 data bits sent LSB first and a stop bit, each 16 baud ticks long, loads the byte into `rx_data_o` and sets `rx_irq_o`.
- R2: While `wue_o` is 1, the receiver starts no byte reception and `rx_idle_o` stays 1, however long the line is held low.
- R3: With `wue_o` at 1, a falling edge on `rx_i` sets `wake_req_o` and `rx_irq_o`, and loads `rx_data_o` with 8'h00.
- R4: A one-cycle pulse on `rd_i` clears `rx_irq_o`. If a set event (a byte completing, or a wake event) falls in the same cycle as the read, the set wins and `rx_irq_o` stays 1.
- R5: After a wake event, `wue_o` and `wake_req_o` clear within a few system clocks of `rx_i` going high. No baud tick is needed for this. Reception then works normally.
- R6: A `wue_set_i` pulse while `rx_idle_o` is 0 is ignored, and `wue_o` stays 0.
- R7: While `sleep_i` is 1 and wake-up is armed, a falling edge on `rx_i` drives `rx_irq_o` high with no clock edge in between.
- R8: While `sleep_i` is 1, no baud tick reaches the receiver, so no byte completes. After sleep ends, a stalled start that finds the line high is dropped and the receiver returns to idle.
- R9: `frame_err_o` is updated when each byte completes: 1 if the stop bit sampled low, 0 if it sampled high.
- R10: A low pulse shorter than half a bit is treated as a false start. It sets no interrupt and leaves `rx_idle_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | 16x oversampling strobe |
| sleep_i | input | 1 | Gates the baud tick; makes the wake interrupt combinational |
| rx_i | input | 1 | Serial input, idle high |
| wue_set_i | input | 1 | Pulse that arms wake-up mode |
| rd_i | input | 1 | Read strobe for the data register; clears the interrupt |
| rx_data_o | output | 8 | Received byte, or 8'h00 after a wake event |
| rx_irq_o | output | 1 | Receive interrupt |
| rx_idle_o | output | 1 | 1 when no byte reception is in progress |
| frame_err_o | output | 1 | Stop bit of the last byte sampled low |
| wue_o | output | 1 | Wake-up mode armed |
| wake_req_o | output | 1 | Asynchronous wake request from the edge capture flop |

## Verification
A read strobe and the completion of a new byte can fall in the same cycle. When they do, the interrupt must stay set. To provoke this, the bench starts each frame on a fixed tick phase. A first frame records the exact cycle in which `rx_data_o` changes. Later frames with the same phase place a one-cycle read on that cycle, and on the cycle after it. The result is judged by `rx_irq_o` once the frame is over: it must be 1 for the coincident read and 0 for the late one. The same rule is exercised during a break, where a read clears the wake interrupt and no second set may follow while the line stays low.

// File: rtl/uart_wk_pkg.sv
package uart_wk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_wk_sync.sv
module uart_wk_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_wk_edge.sv
// Falling-edge capture that runs without any system or baud clock.
module uart_wk_edge (
  input  logic rst_ni,
  input  logic arm_i,
  input  logic rx_i,
  output logic flag_o
);
  logic clr;
  assign clr = ~rst_ni | ~arm_i;

  always_ff @(negedge rx_i or posedge clr) begin
    if (clr) flag_o <= 1'b0;
    else     flag_o <= 1'b1;
  end
endmodule

// File: rtl/uart_wk_rx_core.sv
module uart_wk_rx_core
  import uart_wk_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic          hold_i,
  output logic          idle_o,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          stop_ok_o
);
  localparam int unsigned CW   = $clog2(OVS);
  localparam int unsigned BW   = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [BW-1:0] TOPB = BW'(DW - 1);

  rx_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] sh_q;
  logic          prev_q;
  logic          done_q;
  logic          stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      prev_q <= 1'b1;
      done_q <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      prev_q <= rx_i;
      done_q <= 1'b0;
      if (hold_i) begin
        st_q <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_IDLE: if (prev_q && !rx_i) begin
            st_q  <= ST_START;
            cnt_q <= '0;
          end
          ST_START: if (tick_i) begin
            if (cnt_q == MID) begin
              cnt_q <= '0;
              bit_q <= '0;
              st_q  <= rx_i ? ST_IDLE : ST_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: if (tick_i) begin
            if (cnt_q == LAST) begin
              cnt_q <= '0;
              sh_q  <= {rx_i, sh_q[DW-1:1]};
              if (bit_q == TOPB) st_q <= ST_STOP;
              else               bit_q <= bit_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP: if (tick_i) begin
            if (cnt_q == LAST) begin
              cnt_q  <= '0;
              done_q <= 1'b1;
              stop_q <= rx_i;
              st_q   <= ST_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign idle_o    = (st_q == ST_IDLE);
  assign done_o    = done_q;
  assign data_o    = sh_q;
  assign stop_ok_o = stop_q;
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
  parameter int unsigned DW       = 8,
  parameter int unsigned OVS      = 16,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          baud_tick_i,
  input  logic          sleep_i,
  input  logic          rx_i,
  input  logic          wue_set_i,
  input  logic          rd_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_irq_o,
  output logic          rx_idle_o,
  output logic          frame_err_o,
  output logic          wue_o,
  output logic          wake_req_o
);
  logic          rx_s, wk_flag, wk_s, wk_seen_q;
  logic          tick_en, core_idle, core_done, core_stop_ok;
  logic [DW-1:0] core_data;
  logic          wue_q, irq_q, ferr_q;
  logic [DW-1:0] data_q;
  logic          wk_rise, wk_end, irq_set;

  uart_wk_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_rx_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s)
  );

  uart_wk_edge u_edge (
    .rst_ni(rst_ni), .arm_i(wue_q), .rx_i(rx_i), .flag_o(wk_flag)
  );

  uart_wk_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_wk_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wk_flag), .q_o(wk_s)
  );

  assign tick_en = baud_tick_i & ~sleep_i;

  uart_wk_rx_core #(.DW(DW), .OVS(OVS)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_en), .rx_i(rx_s),
    .hold_i(wue_q), .idle_o(core_idle), .done_o(core_done),
    .data_o(core_data), .stop_ok_o(core_stop_ok)
  );

  assign wk_rise = wue_q & wk_s & ~wk_seen_q;
  assign wk_end  = wue_q & wk_s & rx_s;
  assign irq_set = core_done | wk_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wue_q     <= 1'b0;
      wk_seen_q <= 1'b0;
      irq_q     <= 1'b0;
      ferr_q    <= 1'b0;
      data_q    <= '0;
    end else begin
      wk_seen_q <= wue_q & wk_s;
      if (wue_q) begin
        if (wk_end) wue_q <= 1'b0;
      end else if (wue_set_i && core_idle && !wk_s) begin
        wue_q <= 1'b1;
      end
      // set has priority over the read clear
      if (irq_set)   irq_q <= 1'b1;
      else if (rd_i) irq_q <= 1'b0;
      if (core_done) begin
        data_q <= core_data;
        ferr_q <= ~core_stop_ok;
      end else if (wk_rise) begin
        data_q <= '0;
      end
    end
  end

  assign rx_data_o   = data_q;
  assign rx_irq_o    = irq_q | (wk_flag & sleep_i);
  assign rx_idle_o   = core_idle;
  assign frame_err_o = ferr_q;
  assign wue_o       = wue_q;
  assign wake_req_o  = wk_flag;
endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sleep_i,
  input logic          rd_i,
  input logic [DW-1:0] rx_data_o,
  input logic          rx_irq_o,
  input logic          rx_idle_o,
  input logic          frame_err_o,
  input logic          wue_o,
  input logic          wake_req_o
);
  a_r2_armed_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wue_o |-> rx_idle_o);

  a_r6_busy_arm_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_idle_o && !wue_o) |=> !wue_o);

  a_r5_dummy_on_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wue_o) |-> (rx_data_o == '0));

  a_r4_irq_clear_by_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rx_irq_o) && !sleep_i && !$past(sleep_i)) |-> $past(rd_i));

  a_r9_ferr_with_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_err_o) |-> rx_irq_o);

  a_r3_wake_only_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |-> wue_o);
endmodule

bind uart_wake_rx uart_wake_rx_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .rd_i(rd_i),
  .rx_data_o(rx_data_o), .rx_irq_o(rx_irq_o), .rx_idle_o(rx_idle_o),
  .frame_err_o(frame_err_o), .wue_o(wue_o), .wake_req_o(wake_req_o)
);

// File: tb/tb_uart_wake_rx.sv
`timescale 1ns/100ps
module tb_uart_wake_rx;
  localparam int BIT_CLK = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, tdiv = 1'b0;
  logic       sleep = 1'b0, rx = 1'b1, wue_set = 1'b0, rd = 1'b0;
  logic [7:0] data;
  logic       irq, idle, ferr, wue, wreq;
  int         n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= ~tdiv;
    tick <= tdiv;
  end

  uart_wake_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .sleep_i(sleep),
    .rx_i(rx), .wue_set_i(wue_set), .rd_i(rd), .rx_data_o(data),
    .rx_irq_o(irq), .rx_idle_o(idle), .frame_err_o(ferr), .wue_o(wue),
    .wake_req_o(wreq)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_pulse();
    rd = 1'b1; cyc(1); rd = 1'b0;
  endtask

  task automatic arm();
    wue_set = 1'b1; cyc(1); wue_set = 1'b0;
  endtask

  task automatic align();
    while (tdiv != 1'b0) cyc(1);
  endtask

  // rdpos: stop-bit cycle carrying a one-cycle read (-1 none); k: cycle whose edge updated data
  task automatic send(input logic [7:0] d, input logic stop, input int rdpos, output int k);
    logic [7:0] prev;
    k = -1;
    rx = 1'b0; cyc(BIT_CLK);
    for (int i = 0; i < 8; i++) begin rx = d[i]; cyc(BIT_CLK); end
    rx = stop;
    prev = data;
    for (int j = 0; j < BIT_CLK; j++) begin
      rd = (j == rdpos);
      cyc(1);
      if (k < 0 && data != prev) k = j;
    end
    rd = 1'b0;
    rx = 1'b1;
  endtask

  initial begin
    #(4 * 190000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int k, kref;
    cyc(5);
    rst_n = 1'b1;
    cyc(4);
    chk(irq == 0 && wue == 0 && wreq == 0, "R1 reset irq/wue/wake", {irq, wue, wreq}, 0);
    chk(idle == 1 && ferr == 0, "R1 reset idle/ferr", {idle, ferr}, 2);

    // R1 R9 R4: all byte values
    for (int d = 0; d < 256; d++) begin
      send(8'(d), 1'b1, -1, k);
      cyc(4);
      chk(irq == 1, "R1 irq after byte", irq, 1);
      chk(data == 8'(d), "R1 data", data, d);
      chk(ferr == 0, "R9 ferr clear on good stop", ferr, 0);
      rd_pulse();
      chk(irq == 0, "R4 read clears irq", irq, 0);
    end

    // R9 framing error
    send(8'hA5, 1'b0, -1, k);
    cyc(4);
    chk(ferr == 1, "R9 ferr on low stop", ferr, 1);
    chk(data == 8'hA5, "R9 data with bad stop", data, 8'hA5);
    rd_pulse();
    cyc(64);
    send(8'h5C, 1'b1, -1, k);
    cyc(4);
    chk(ferr == 0, "R9 ferr cleared by next good byte", ferr, 0);
    rd_pulse();

    // R10 false start
    rx = 1'b0; cyc(6); rx = 1'b1; cyc(64);
    chk(irq == 0, "R10 no irq on glitch", irq, 0);
    chk(idle == 1, "R10 idle after glitch", idle, 1);

    // R6 arming ignored while busy
    fork
      send(8'h3C, 1'b1, -1, k);
      begin cyc(100); arm(); chk(wue == 0, "R6 arm ignored while busy", wue, 0); end
    join
    cyc(4);
    chk(data == 8'h3C && irq == 1, "R6 byte still received", data, 8'h3C);
    rd_pulse();
    cyc(32);

    // R2 R3 R4 R5 wake with clocks running
    arm();
    chk(wue == 1, "R3 armed", wue, 1);
    rx = 1'b0; cyc(10);
    chk(irq == 1 && wreq == 1, "R3 wake edge raises irq/req", {irq, wreq}, 3);
    chk(data == 8'h00, "R3 dummy data", data, 0);
    cyc(400);
    chk(idle == 1, "R2 idle while armed and low", idle, 1);
    chk(wue == 1, "R5 armed until line rises", wue, 1);
    rd_pulse();
    cyc(4);
    chk(irq == 0, "R4 read clears wake irq during break", irq, 0);
    rx = 1'b1; cyc(6);
    chk(wue == 0 && wreq == 0, "R5 self clear", {wue, wreq}, 0);
    chk(irq == 0, "R5 no second irq on rise", irq, 0);
    cyc(32);
    send(8'h5A, 1'b1, -1, k);
    cyc(4);
    chk(data == 8'h5A && irq == 1, "R5 normal reception resumes", data, 8'h5A);
    rd_pulse();

    // R8 sleep gates the baud tick
    cyc(32);
    sleep = 1'b1;
    send(8'h81, 1'b1, -1, k);
    cyc(8);
    chk(irq == 0, "R8 no byte during sleep", irq, 0);
    sleep = 1'b0; cyc(64);
    chk(idle == 1 && irq == 0, "R8 stalled start dropped", {idle, irq}, 2);

    // R7 asynchronous irq in sleep; R5 clear without ticks
    sleep = 1'b1;
    arm();
    rx = 1'b0; #0.5;
    chk(irq == 1 && wreq == 1, "R7 async irq in sleep", {irq, wreq}, 3);
    cyc(30);
    rx = 1'b1; cyc(6);
    chk(wue == 0, "R5 self clear with tick gated", wue, 0);
    chk(data == 8'h00 && irq == 1, "R3 dummy data in sleep", data, 0);
    sleep = 1'b0;
    rd_pulse();
    cyc(32);

    // R4 read coincident with byte completion
    align();
    send(8'h11, 1'b1, -1, kref);
    cyc(32); align();
    send(8'h22, 1'b1, kref, k);
    cyc(4);
    chk(kref >= 0, "R4 completion cycle located", kref, 0);
    chk(irq == 1 && data == 8'h22, "R4 set wins over coincident read", irq, 1);
    cyc(32); align();
    send(8'h33, 1'b1, kref + 1, k);
    cyc(4);
    chk(irq == 0 && data == 8'h33, "R4 read after completion clears", irq, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule